// File: doc/BRIEF.md
# Compressed Opcode Page Tracker

This block keeps track of which alternate opcode page applies to 16-bit compressed instructions. A page-select command carries a 3-bit subpage number and a 4-bit length. A finite length gives the number of retired instructions the page covers. The all-ones length keeps the page in force until a command changes it. The instruction decoder reads the current subpage and the active flag each cycle. When the flag is low, the decoder uses the default encoding and the subpage output reads zero.

Selections are nested. Each new selection is pushed onto a small stack and becomes the current page. When the current page expires, the entry below it takes over again with the count it had left. A page expires when its countdown ends, when a branch is taken, or when a pop command discards it. A clear command empties the whole stack at once. A push onto a full stack is dropped, and a sticky overflow flag is raised.

All commands arriving in the same cycle are resolved by a fixed priority. Only one stack operation takes effect per cycle. The stack size is a parameter of at most 7, so the depth always fits the 3-bit depth output.

Top module: `cpt_page_tracker`

## Requirements
- R1: After synchronous reset, `page_out` is 0, `page_active` is 0, `depth_out` is 0 and `overflow` is 0.
- R2: A select with a length from 1 to 15 on a stack that is not full makes `sel_page` the current page on the next cycle, sets `page_active`, and raises `depth_out` by one.
- R3: A select with a non-zero length on a full stack leaves the depth and the current page unchanged and sets `overflow`. `overflow` then stays set until a clear command or reset.
- R4: A selection with finite length L (1 to 14) stays current through L-1 counted retires and ends on the L-th counted retire. A retire pulse in the same cycle as the select belongs to the select instruction and is not counted.
- R5: When the current selection ends, the entry below it becomes current again with its remaining count unchanged. If no entry is left, the default encoding applies.
- R6: A selection with length 15 (all ones) is permanent: neither retires nor taken branches end it.
- R7: A taken branch ends the current non-permanent selection and removes exactly one stack level.
- R8: A clear command empties the stack, returns to the default encoding and clears `overflow`.
- R9: A pop command discards only the top entry and restores the one below it. On an empty stack it has no effect.
- R10: A select with length 0 causes no change in its cycle, even when a branch or retire arrives in the same cycle.
- R11: Commands in the same cycle are resolved in this priority order: clear, pop, select, branch, retire. Only the winner acts.
- R12: Whenever `depth_out` is 0, `page_out` is 0 and `page_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_valid | input | 1 | Page-select command |
| sel_page | input | 3 | Subpage number of the select |
| sel_len | input | 4 | Length of the select; 15 is permanent, 0 is ignored |
| retire | input | 1 | One instruction retired |
| branch_taken | input | 1 | A branch was taken |
| clear_cmd | input | 1 | Empty the stack and return to default |
| pop_cmd | input | 1 | Discard the top stack entry |
| page_out | output | 3 | Current subpage, 0 when inactive |
| page_active | output | 1 | An alternate page is in force |
| depth_out | output | 3 | Number of stacked selections |
| overflow | output | 1 | Sticky flag: a select was dropped on a full stack |

## Verification
On every cycle, the assertions check the single-step depth changes: a push, a pop, a clear, an overflow-dropped select and a zero-length select, plus the stickiness of the overflow flag. The remaining counts are not visible at the ports. So the countdown length, the exact retire on which a page ends, the restoring of an outer page with its remaining count intact, and the immunity of permanent pages can only be shown by the bench's scenarios. The bench sweeps every subpage against every finite length and then runs nesting, overflow, pop and priority sequences.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

    localparam int SUB_W   = 3;
    localparam int LEN_W   = 4;
    localparam int DEPTH_W = 3;

    localparam logic [LEN_W-1:0] LEN_PERM = '1;

    typedef struct packed {
        logic [SUB_W-1:0] page;
        logic [LEN_W-1:0] left;
        logic             perm;
    } page_ent_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CLEAR,
        OP_POP,
        OP_PUSH,
        OP_BRANCH,
        OP_TICK
    } stk_op_e;

    function automatic page_ent_t make_ent(input logic [SUB_W-1:0] pg,
                                           input logic [LEN_W-1:0] len);
        page_ent_t e;
        e.page = pg;
        e.left = len;
        e.perm = (len == LEN_PERM);
        return e;
    endfunction

    // true when one more counted retire ends this entry
    function automatic logic ends_on_tick(input page_ent_t e);
        return !e.perm && (e.left == LEN_W'(1));
    endfunction

endpackage

// File: rtl/cpt_cmd_arb.sv
module cpt_cmd_arb
    import cpt_pkg::*;
(
    input  logic             sel_valid,
    input  logic [LEN_W-1:0] sel_len,
    input  logic             retire,
    input  logic             branch_taken,
    input  logic             clear_cmd,
    input  logic             pop_cmd,
    output stk_op_e          op
);

    always_comb begin
        if (clear_cmd)
            op = OP_CLEAR;
        else if (pop_cmd)
            op = OP_POP;
        else if (sel_valid)
            // zero length swallows the cycle, including its own retire
            op = (sel_len != '0) ? OP_PUSH : OP_IDLE;
        else if (branch_taken)
            op = OP_BRANCH;
        else if (retire)
            op = OP_TICK;
        else
            op = OP_IDLE;
    end

endmodule

// File: rtl/cpt_page_stack.sv
module cpt_page_stack
    import cpt_pkg::*;
#(
    parameter int N = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  stk_op_e            op,
    input  page_ent_t          new_ent,
    output page_ent_t          top_ent,
    output logic [DEPTH_W-1:0] depth,
    output logic               full
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(N);

    page_ent_t          ents [N];
    logic [DEPTH_W-1:0] depth_q;

    assign depth = depth_q;
    assign full  = (depth_q == DEPTH_MAX);

    always_comb begin
        top_ent = '0;
        for (int i = 0; i < N; i++) begin
            if (depth_q == DEPTH_W'(i + 1))
                top_ent = ents[i];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        page_ent_t slot_q;
        logic      wr_push;
        logic      wr_tick;

        assign wr_push = (op == OP_PUSH) && (depth_q == DEPTH_W'(g));
        assign wr_tick = (op == OP_TICK) && (depth_q == DEPTH_W'(g + 1))
                         && !slot_q.perm && (slot_q.left > LEN_W'(1));

        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr_push)
                slot_q <= new_ent;
            else if (wr_tick)
                slot_q.left <= slot_q.left - LEN_W'(1);
        end

        assign ents[g] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR:  depth_q <= '0;
                OP_POP:    if (depth_q != '0) depth_q <= depth_q - DEPTH_W'(1);
                OP_PUSH:   if (!full) depth_q <= depth_q + DEPTH_W'(1);
                OP_BRANCH: if (depth_q != '0 && !top_ent.perm)
                               depth_q <= depth_q - DEPTH_W'(1);
                OP_TICK:   if (depth_q != '0 && ends_on_tick(top_ent))
                               depth_q <= depth_q - DEPTH_W'(1);
                default:   depth_q <= depth_q;
            endcase
        end
    end

endmodule

// File: rtl/cpt_page_tracker.sv
module cpt_page_tracker
    import cpt_pkg::*;
#(
    parameter int STACK_N = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_valid,
    input  logic [2:0] sel_page,
    input  logic [3:0] sel_len,
    input  logic       retire,
    input  logic       branch_taken,
    input  logic       clear_cmd,
    input  logic       pop_cmd,
    output logic [2:0] page_out,
    output logic       page_active,
    output logic [2:0] depth_out,
    output logic       overflow
);

    stk_op_e            op;
    page_ent_t          top_ent;
    logic [DEPTH_W-1:0] depth;
    logic               full;
    logic               ovf_q;

    cpt_cmd_arb u_arb (
        .sel_valid    (sel_valid),
        .sel_len      (sel_len),
        .retire       (retire),
        .branch_taken (branch_taken),
        .clear_cmd    (clear_cmd),
        .pop_cmd      (pop_cmd),
        .op           (op)
    );

    cpt_page_stack #(.N(STACK_N)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .new_ent (make_ent(sel_page, sel_len)),
        .top_ent (top_ent),
        .depth   (depth),
        .full    (full)
    );

    always_ff @(posedge clk) begin
        if (rst || op == OP_CLEAR)
            ovf_q <= 1'b0;
        else if (op == OP_PUSH && full)
            ovf_q <= 1'b1;
    end

    assign page_active = (depth != '0);
    assign page_out    = page_active ? top_ent.page : '0;
    assign depth_out   = depth;
    assign overflow    = ovf_q;

endmodule

// File: rtl/cpt_page_tracker_chk.sv
module cpt_page_tracker_chk #(
    parameter int STACK_N = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       sel_valid,
    input logic [2:0] sel_page,
    input logic [3:0] sel_len,
    input logic       retire,
    input logic       branch_taken,
    input logic       clear_cmd,
    input logic       pop_cmd,
    input logic [2:0] page_out,
    input logic       page_active,
    input logic [2:0] depth_out,
    input logic       overflow
);

    logic push_try;
    assign push_try = !clear_cmd && !pop_cmd && sel_valid && (sel_len != 4'd0);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clear_cmd |=> (depth_out == 3'd0) && !overflow && !page_active);

    p_pop_one_r9: assert property (@(posedge clk) disable iff (rst)
        (!clear_cmd && pop_cmd && depth_out != 3'd0)
        |=> depth_out == 3'($past(depth_out) - 3'd1));

    p_push_r2: assert property (@(posedge clk) disable iff (rst)
        (push_try && int'(depth_out) < STACK_N)
        |=> (depth_out == 3'($past(depth_out) + 3'd1)) && page_active
            && (page_out == $past(sel_page)));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (push_try && int'(depth_out) == STACK_N)
        |=> overflow && (depth_out == $past(depth_out))
            && (page_out == $past(page_out)));

    p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (overflow && !clear_cmd) |=> overflow);

    p_zero_len_r10: assert property (@(posedge clk) disable iff (rst)
        (!clear_cmd && !pop_cmd && sel_valid && sel_len == 4'd0)
        |=> $stable(depth_out) && $stable(page_out));

    p_branch_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!clear_cmd && !pop_cmd && !sel_valid && branch_taken)
        |=> (depth_out == $past(depth_out))
            || (depth_out == 3'($past(depth_out) - 3'd1)));

    p_default_r12: assert property (@(posedge clk) disable iff (rst)
        (depth_out == 3'd0) |-> (page_out == 3'd0) && !page_active);

    p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
        int'(depth_out) <= STACK_N);

endmodule

bind cpt_page_tracker cpt_page_tracker_chk #(.STACK_N(STACK_N)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sel_valid    (sel_valid),
    .sel_page     (sel_page),
    .sel_len      (sel_len),
    .retire       (retire),
    .branch_taken (branch_taken),
    .clear_cmd    (clear_cmd),
    .pop_cmd      (pop_cmd),
    .page_out     (page_out),
    .page_active  (page_active),
    .depth_out    (depth_out),
    .overflow     (overflow)
);

// File: tb/cpt_page_tracker_test.sv
`timescale 1ns/1ps
module cpt_page_tracker_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_valid = 1'b0;
    logic [2:0] sel_page = '0;
    logic [3:0] sel_len = '0;
    logic       retire = 1'b0;
    logic       branch_taken = 1'b0;
    logic       clear_cmd = 1'b0;
    logic       pop_cmd = 1'b0;
    logic [2:0] page_out;
    logic       page_active;
    logic [2:0] depth_out;
    logic       overflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cpt_page_tracker #(.STACK_N(4)) uut (
        .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_page(sel_page),
        .sel_len(sel_len), .retire(retire), .branch_taken(branch_taken),
        .clear_cmd(clear_cmd), .pop_cmd(pop_cmd), .page_out(page_out),
        .page_active(page_active), .depth_out(depth_out), .overflow(overflow)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic expect_st(input string tag, input int pg, input int act,
                             input int dp, input int ov);
        chk(tag, "page_out", int'(page_out), pg);
        chk(tag, "page_active", int'(page_active), act);
        chk(tag, "depth_out", int'(depth_out), dp);
        chk(tag, "overflow", int'(overflow), ov);
    endtask

    // one clock: drive at negedge, outputs settle just after posedge
    task automatic step(input logic s, input int p, input int l, input logic rt,
                        input logic br, input logic clr, input logic pp);
        @(negedge clk);
        sel_valid = s; sel_page = 3'(p); sel_len = 4'(l);
        retire = rt; branch_taken = br; clear_cmd = clr; pop_cmd = pp;
        @(posedge clk);
        #1;
        sel_valid = 0; sel_page = '0; sel_len = '0;
        retire = 0; branch_taken = 0; clear_cmd = 0; pop_cmd = 0;
    endtask

    task automatic do_sel(input int p, input int l);
        step(1, p, l, 0, 0, 0, 0);
    endtask
    task automatic do_ret();
        step(0, 0, 0, 1, 0, 0, 0);
    endtask
    task automatic do_br();
        step(0, 0, 0, 0, 1, 0, 0);
    endtask
    task automatic do_clr();
        step(0, 0, 0, 0, 0, 1, 0);
    endtask
    task automatic do_pop();
        step(0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 / R12: reset state
        expect_st("R1", 0, 0, 0, 0);

        // R2 / R4 / R5: every subpage against every finite length
        for (int p = 0; p < 8; p++) begin
            for (int l = 1; l < 15; l++) begin
                do_clr();
                step(1, p, l, 1, 0, 0, 0);   // own retire is not counted (R4)
                expect_st("R2", p, 1, 1, 0);
                for (int k = 1; k < l; k++) do_ret();
                chk("R4", "active before last retire", int'(page_active), 1);
                chk("R4", "page before last retire", int'(page_out), p);
                do_ret();
                expect_st("R5", 0, 0, 0, 0);   // empty -> default (R12)
            end
        end

        // R6: permanent page survives retires and branches
        do_clr();
        do_sel(5, 15);
        for (int k = 0; k < 40; k++) do_ret();
        do_br();
        expect_st("R6", 5, 1, 1, 0);

        // R7: branch ends one non-permanent level only
        do_clr();
        do_sel(2, 15);
        do_sel(6, 9);
        expect_st("R7", 6, 1, 2, 0);
        do_br();
        expect_st("R7", 2, 1, 1, 0);
        do_br();
        expect_st("R6", 2, 1, 1, 0);

        // R5: outer page resumes with its remaining count
        do_clr();
        do_sel(1, 5);
        do_ret(); do_ret();             // 3 left
        do_sel(4, 3);
        do_ret(); do_ret();
        expect_st("R5", 4, 1, 2, 0);
        do_ret();
        expect_st("R5", 1, 1, 1, 0);
        do_ret(); do_ret();
        expect_st("R5", 1, 1, 1, 0);
        do_ret();
        expect_st("R5", 0, 0, 0, 0);

        // R3: overflow on a full stack, sticky until clear (R8)
        do_clr();
        for (int k = 1; k <= 4; k++) do_sel(k, 15);
        expect_st("R3", 4, 1, 4, 0);
        do_sel(7, 15);
        expect_st("R3", 4, 1, 4, 1);
        do_pop();
        expect_st("R3", 3, 1, 3, 1);
        do_clr();
        expect_st("R8", 0, 0, 0, 0);

        // R9: pop on empty, pop restores the entry below
        do_pop();
        expect_st("R9", 0, 0, 0, 0);
        do_sel(3, 9);
        do_sel(6, 2);
        do_ret();
        do_pop();
        expect_st("R9", 3, 1, 1, 0);
        for (int k = 0; k < 8; k++) do_ret();
        expect_st("R9", 3, 1, 1, 0);
        do_ret();
        expect_st("R9", 0, 0, 0, 0);

        // R10: zero-length select does nothing, even its retire
        do_clr();
        do_sel(2, 4);
        step(1, 7, 0, 1, 1, 0, 0);
        expect_st("R10", 2, 1, 1, 0);
        do_ret(); do_ret(); do_ret();
        expect_st("R10", 2, 1, 1, 0);
        do_ret();
        expect_st("R10", 0, 0, 0, 0);

        // R11: same-cycle priority
        do_clr();
        do_sel(3, 15);
        step(1, 5, 4, 1, 1, 1, 1);      // clear wins
        expect_st("R11", 0, 0, 0, 0);
        do_sel(3, 15);
        do_sel(1, 4);
        step(1, 6, 4, 0, 0, 0, 1);      // pop wins over select
        expect_st("R11", 3, 1, 1, 0);
        step(1, 6, 2, 1, 1, 0, 0);      // select wins over branch and retire
        expect_st("R11", 6, 1, 2, 0);
        step(0, 0, 0, 1, 1, 0, 0);      // branch wins over retire
        expect_st("R11", 3, 1, 1, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule